// File: doc/BRIEF.md
# Doubleword Store Execution Unit

This unit carries out the four 64-bit integer store instructions of a big-endian RISC core with 32-bit instruction words. It handles two addressing forms: a base register plus a word-scaled immediate displacement, and a base register plus an index register. Each form comes in a plain flavour and an update flavour. The core presents the instruction word together with the three operand values it has read from the register file. The unit decodes the word and forms the effective address. It places the eight source bytes onto the byte lanes of a 128-byte cache line port, and it issues one line access, or two when the doubleword runs past the end of a line. The update flavours then return the address to the register file.

The unit also keeps one load-reservation line. An executed store that touches the reserved line cancels the reservation and raises a one-cycle notice. An update-flavour encoding that names register 0 as its base is not a legal instruction. The unit flags it and does nothing else.

Top module: `dw_store_unit`

## Requirements
- R1: Only four encodings start a store. The primary opcode sits in instr_word[31:26]. Opcode 62 with instr_word[1:0]=0 is the plain displacement store, and with instr_word[1:0]=1 it is the displacement store with update. Opcode 31 with instr_word[10:1]=149 is the plain indexed store, and with 181 it is the indexed store with update. Every other word causes no request, no writeback, no flag and no reservation notice.
- R2: The displacement is the signed 14-bit field instr_word[15:2]. Two zero bits are appended below it and the result is sign-extended to 64 bits, so the byte offset spans -32768 to +32764.
- R3: The base-register field is instr_word[20:16]. When a plain store gives 0 in this field, the base is the constant zero and ra_val is ignored. Otherwise the base is ra_val, and the index form adds rb_val (field instr_word[15:11]).
- R4: The effective address (EA) is the 64-bit base-plus-offset sum, wrapping at 2^64. Only its low 32 bits are used for memory and writeback.
- R5: Byte k of the source (rs_val[63-8k:56-8k], k=0..7) is written to byte address EA+k. mem_addr is always line aligned (low 7 bits zero). Byte lane j of the line is mem_wdata[8j+7:8j], enabled by mem_be[j].
- R6: When EA[6:0] > 120, the store is issued as two accesses. The first goes to the line holding EA and carries only the bytes in that line. The second goes to the next line, with the address wrapping modulo 2^32, and carries the remaining bytes at lanes 0 upward. Stores that do not cross a line use one access. Misaligned stores raise no fault.
- R7: The first access is requested in the cycle after the instruction is accepted. A request holds mem_addr, mem_be and mem_wdata steady until a cycle with mem_ack high. busy is high while any access is outstanding. An instruction presented while busy is dropped.
- R8: An update form pulses wb_valid for one cycle, in the cycle after its last access is acknowledged. wb_idx carries the base-register field and wb_data carries EA zero-extended to 64 bits. Plain forms never pulse wb_valid.
- R9: An update form whose base-register field is 0 pulses illegal for one cycle, in the cycle after it is presented. It makes no memory request, no writeback, no reservation notice and no change to the reservation.
- R10: A cycle with resv_set high loads the reservation with the line of resv_addr and marks it valid. An executed store whose accessed lines include the reserved line pulses resv_kill in its first request cycle and clears the reservation. A store to other lines leaves the reservation intact and gives no pulse.
- R11: After reset, mem_req, busy, wb_valid, illegal and resv_kill are low and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word and operands are presented |
| instr_word | input | 32 | Instruction word, bit 31 is the first-numbered bit |
| rs_val | input | 64 | Value of the source register |
| ra_val | input | 64 | Value of the register named by the base field |
| rb_val | input | 64 | Value of the register named by the index field |
| busy | output | 1 | A store access is outstanding; new instructions are dropped |
| mem_req | output | 1 | Line write request |
| mem_addr | output | 32 | Line-aligned address of the access |
| mem_be | output | 128 | Per-byte lane enables |
| mem_wdata | output | 1024 | Line write data, lane j at bits 8j+7:8j |
| mem_ack | input | 1 | Cache accepts the current request |
| wb_valid | output | 1 | Register writeback pulse for update forms |
| wb_idx | output | 5 | Register number to write |
| wb_data | output | 64 | Zero-extended effective address |
| resv_set | input | 1 | Establish a reservation |
| resv_addr | input | 32 | Address of the new reservation |
| resv_kill | output | 1 | Reservation cancelled by this store |
| illegal | output | 1 | Invalid update-form encoding seen |

## Verification
The bench aims at the places where address formation goes wrong quietly. A design that used register 0 instead of the zero base would store to the ra_val address. One that skipped the sign extension or the scaling of the displacement would land far from the intended byte, which the most negative displacement exposes. One that truncated the address too early, or dropped the wrap, would miss the store that crosses from the top of the address space into line zero. Line crossings at offsets 125 and 124 are checked lane by lane: a wrong split threshold or lane order would put bytes in the wrong line, or reverse them. The bench also holds off the acknowledge while a second instruction is presented, to expose a design that drops its data or takes the new word. Reservation cases cover a hit on the second line of a split store, a hit followed by a second store to the same line, and an illegal encoding that must leave the reservation untouched.

// File: rtl/dw_store_pkg.sv
package dw_store_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;

    localparam logic [5:0] OPC_DSFORM = 6'd62;
    localparam logic [5:0] OPC_XFORM  = 6'd31;
    localparam logic [9:0] XO_PLAIN   = 10'd149;
    localparam logic [9:0] XO_UPDATE  = 10'd181;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_SECOND = 2'd2
    } st_phase_e;

endpackage

// File: rtl/dw_store_decode.sv
module dw_store_decode
    import dw_store_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  ra_val,
    input  logic [DATA_W-1:0]  rb_val,
    output logic               is_store,
    output logic               is_update,
    output logic               bad_form,
    output logic [REG_W-1:0]   base_idx,
    output logic [DATA_W-1:0]  ea_full
);
    logic [5:0]        opc;
    logic              ds_hit;
    logic              x_hit;
    logic              zero_base;
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] offset;

    always_comb begin
        opc       = instr[31:26];
        base_idx  = instr[20:16];
        ds_hit    = (opc == OPC_DSFORM) && (instr[1] == 1'b0);
        x_hit     = (opc == OPC_XFORM) &&
                    ((instr[10:1] == XO_PLAIN) || (instr[10:1] == XO_UPDATE));
        is_store  = ds_hit || x_hit;
        is_update = ds_hit ? instr[0] : (instr[10:1] == XO_UPDATE);
        zero_base = (base_idx == '0);
        bad_form  = is_store && is_update && zero_base;

        base   = (zero_base && !is_update) ? '0 : ra_val;
        offset = ds_hit ? {{(DATA_W-16){instr[15]}}, instr[15:2], 2'b00} : rb_val;
        ea_full = base + offset;
    end
endmodule

// File: rtl/dw_lane_place.sv
module dw_lane_place #(
    parameter int LINE_BYTES = 128,
    parameter int NBYTES     = 8,
    localparam int LOFS_W    = $clog2(LINE_BYTES),
    localparam int LANE_W    = LINE_BYTES * 8
) (
    input  logic [LOFS_W-1:0]     ofs,
    input  logic [NBYTES*8-1:0]   src,
    output logic [LINE_BYTES-1:0] be_lo,
    output logic [LINE_BYTES-1:0] be_hi,
    output logic [LANE_W-1:0]     wd_lo,
    output logic [LANE_W-1:0]     wd_hi,
    output logic                  crosses
);
    localparam logic [LOFS_W:0] LAST_FIT = (LOFS_W+1)'(LINE_BYTES - NBYTES);

    logic [LOFS_W:0] pos;
    logic [7:0]      byte_v;

    always_comb begin
        be_lo   = '0;
        be_hi   = '0;
        wd_lo   = '0;
        wd_hi   = '0;
        pos     = '0;
        byte_v  = '0;
        crosses = ({1'b0, ofs} > LAST_FIT);
        for (int k = 0; k < NBYTES; k++) begin
            pos    = {1'b0, ofs} + (LOFS_W+1)'(k);
            byte_v = src[(NBYTES-1-k)*8 +: 8];
            if (pos[LOFS_W]) begin
                be_hi[pos[LOFS_W-1:0]]         = 1'b1;
                wd_hi[pos[LOFS_W-1:0]*8 +: 8]  = byte_v;
            end else begin
                be_lo[pos[LOFS_W-1:0]]         = 1'b1;
                wd_lo[pos[LOFS_W-1:0]*8 +: 8]  = byte_v;
            end
        end
    end
endmodule

// File: rtl/dw_resv_track.sv
module dw_resv_track #(
    parameter int LN_W = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set,
    input  logic [LN_W-1:0] set_line,
    input  logic            probe,
    input  logic [LN_W-1:0] line_a,
    input  logic [LN_W-1:0] line_b,
    input  logic            use_b,
    output logic            kill
);
    typedef struct packed {
        logic            valid;
        logic [LN_W-1:0] line;
        logic            kill;
    } rv_t;

    rv_t r_d, r_q;
    logic hit;

    always_comb begin
        r_d  = r_q;
        hit  = probe && r_q.valid &&
               ((line_a == r_q.line) || (use_b && (line_b == r_q.line)));
        r_d.kill = hit;
        if (hit) r_d.valid = 1'b0;
        if (set) begin
            r_d.valid = 1'b1;
            r_d.line  = set_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign kill = r_q.kill;
endmodule

// File: rtl/dw_store_unit.sv
module dw_store_unit
    import dw_store_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 128,
    localparam int NBYTES    = DATA_W / 8,
    localparam int LOFS_W    = $clog2(LINE_BYTES),
    localparam int LN_W      = ADDR_W - LOFS_W,
    localparam int LANE_W    = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_valid,
    input  logic [31:0]           instr_word,
    input  logic [DATA_W-1:0]     rs_val,
    input  logic [DATA_W-1:0]     ra_val,
    input  logic [DATA_W-1:0]     rb_val,
    output logic                  busy,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_BYTES-1:0] mem_be,
    output logic [LANE_W-1:0]     mem_wdata,
    input  logic                  mem_ack,
    output logic                  wb_valid,
    output logic [4:0]            wb_idx,
    output logic [DATA_W-1:0]     wb_data,
    input  logic                  resv_set,
    input  logic [ADDR_W-1:0]     resv_addr,
    output logic                  resv_kill,
    output logic                  illegal
);
    typedef struct packed {
        st_phase_e          phase;
        logic [ADDR_W-1:0]  ea;
        logic [DATA_W-1:0]  src;
        logic               upd;
        logic [REG_W-1:0]   ra;
        logic               wb_v;
        logic               bad;
    } su_t;

    su_t s_d, s_q;

    logic              dec_store, dec_upd, dec_bad;
    logic [REG_W-1:0]  dec_ra;
    logic [DATA_W-1:0] dec_ea;
    logic              accept, go;
    logic [ADDR_W-1:0] ea_new;
    logic              new_cross;

    logic [LINE_BYTES-1:0] be_lo, be_hi;
    logic [LANE_W-1:0]     wd_lo, wd_hi;
    logic                  q_cross;
    logic [LN_W-1:0]       q_line;

    dw_store_decode #(.DATA_W(DATA_W)) u_dec (
        .instr     (instr_word),
        .ra_val    (ra_val),
        .rb_val    (rb_val),
        .is_store  (dec_store),
        .is_update (dec_upd),
        .bad_form  (dec_bad),
        .base_idx  (dec_ra),
        .ea_full   (dec_ea)
    );

    dw_lane_place #(.LINE_BYTES(LINE_BYTES), .NBYTES(NBYTES)) u_place (
        .ofs     (s_q.ea[LOFS_W-1:0]),
        .src     (s_q.src),
        .be_lo   (be_lo),
        .be_hi   (be_hi),
        .wd_lo   (wd_lo),
        .wd_hi   (wd_hi),
        .crosses (q_cross)
    );

    always_comb begin
        busy      = (s_q.phase != ST_IDLE);
        accept    = instr_valid && !busy && dec_store;
        go        = accept && !dec_bad;
        ea_new    = dec_ea[ADDR_W-1:0];
        new_cross = (ea_new[LOFS_W-1:0] > LOFS_W'(LINE_BYTES - NBYTES));
        q_line    = s_q.ea[ADDR_W-1:LOFS_W];

        s_d      = s_q;
        s_d.wb_v = 1'b0;
        s_d.bad  = accept && dec_bad;

        unique case (s_q.phase)
            ST_IDLE: begin
                if (go) begin
                    s_d.phase = ST_FIRST;
                    s_d.ea    = ea_new;
                    s_d.src   = rs_val;
                    s_d.upd   = dec_upd;
                    s_d.ra    = dec_ra;
                end
            end
            ST_FIRST: begin
                if (mem_ack) begin
                    if (q_cross) begin
                        s_d.phase = ST_SECOND;
                    end else begin
                        s_d.phase = ST_IDLE;
                        s_d.wb_v  = s_q.upd;
                    end
                end
            end
            ST_SECOND: begin
                if (mem_ack) begin
                    s_d.phase = ST_IDLE;
                    s_d.wb_v  = s_q.upd;
                end
            end
            default: s_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    dw_resv_track #(.LN_W(LN_W)) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (resv_set),
        .set_line (resv_addr[ADDR_W-1:LOFS_W]),
        .probe    (go),
        .line_a   (ea_new[ADDR_W-1:LOFS_W]),
        .line_b   (ea_new[ADDR_W-1:LOFS_W] + LN_W'(1)),
        .use_b    (new_cross),
        .kill     (resv_kill)
    );

    always_comb begin
        mem_req   = (s_q.phase == ST_FIRST) || (s_q.phase == ST_SECOND);
        if (s_q.phase == ST_SECOND) begin
            mem_addr  = {q_line + LN_W'(1), {LOFS_W{1'b0}}};
            mem_be    = be_hi;
            mem_wdata = wd_hi;
        end else begin
            mem_addr  = {q_line, {LOFS_W{1'b0}}};
            mem_be    = mem_req ? be_lo : '0;
            mem_wdata = wd_lo;
        end
        wb_valid = s_q.wb_v;
        wb_idx   = s_q.ra;
        wb_data  = {{(DATA_W-ADDR_W){1'b0}}, s_q.ea};
        illegal  = s_q.bad;
    end
endmodule

// File: rtl/dw_store_unit_chk.sv
module dw_store_unit_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int NBYTES     = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  instr_valid,
    input logic                  busy,
    input logic                  mem_req,
    input logic                  mem_ack,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [LINE_BYTES-1:0] mem_be,
    input logic                  wb_valid,
    input logic                  illegal,
    input logic                  resv_kill
);
    localparam int LOFS_W = $clog2(LINE_BYTES);

    assert_line_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LOFS_W-1:0] == '0) &&
                    ($countones(mem_be) >= 1) && ($countones(mem_be) <= NBYTES));

    assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_be));

    assert_no_req_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_update_after_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid) |-> $past(mem_req && mem_ack));

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_req && !wb_valid && !resv_kill);

    assert_kill_from_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resv_kill |-> $past(instr_valid && !busy));
endmodule

bind dw_store_unit dw_store_unit_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NBYTES(NBYTES)
) u_chk (.*);

// File: tb/tb_dw_store_unit.sv
module tb_dw_store_unit;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr_word = '0;
    logic [63:0]   rs_val = '0, ra_val = '0, rb_val = '0;
    logic          busy, mem_req, mem_ack = 1'b1;
    logic [31:0]   mem_addr;
    logic [127:0]  mem_be;
    logic [1023:0] mem_wdata;
    logic          wb_valid;
    logic [4:0]    wb_idx;
    logic [63:0]   wb_data;
    logic          resv_set = 1'b0;
    logic [31:0]   resv_addr = '0;
    logic          resv_kill, illegal;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dw_store_unit dut (.*);

    function automatic logic [31:0] mk_ds(input logic [4:0] rs, input logic [4:0] ra,
                                          input logic [13:0] ds, input logic [1:0] xo);
        return {6'd62, rs, ra, ds, xo};
    endfunction

    function automatic logic [31:0] mk_x(input logic [4:0] rs, input logic [4:0] ra,
                                         input logic [4:0] rb, input logic [9:0] xo);
        return {6'd31, rs, ra, rb, xo, 1'b0};
    endfunction

    typedef struct packed {
        logic [31:0] iw;
        logic [63:0] ra;
        logic [63:0] rb;
        logic [63:0] rs;
        logic [31:0] ea;
        logic        st;
        logic        upd;
        logic        bad;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [0:NV-1] = '{
        '{mk_ds(5'd3, 5'd4, 14'd2, 2'd0), 64'h1000, 64'h0, 64'h0102030405060708, 32'h1008, 1'b1, 1'b0, 1'b0},
        '{mk_ds(5'd6, 5'd0, 14'h3FFF, 2'd0), 64'h5555, 64'h0, 64'h1122334455667788, 32'hFFFFFFFC, 1'b1, 1'b0, 1'b0},
        '{mk_ds(5'd9, 5'd5, 14'd3, 2'd1), 64'h2000, 64'h0, 64'hA0A1A2A3A4A5A6A7, 32'h200C, 1'b1, 1'b1, 1'b0},
        '{mk_x(5'd10, 5'd0, 5'd11, 10'd149), 64'h9999, 64'h3001, 64'hCAFEF00D12345678, 32'h3001, 1'b1, 1'b0, 1'b0},
        '{mk_x(5'd12, 5'd7, 5'd8, 10'd181), 64'hFFFFFFFF00000100, 64'h10, 64'h0F1E2D3C4B5A6978, 32'h0110, 1'b1, 1'b1, 1'b0},
        '{mk_x(5'd13, 5'd2, 5'd14, 10'd149), 64'h40, 64'h3D, 64'hDEADBEEF01020304, 32'h007D, 1'b1, 1'b0, 1'b0},
        '{mk_ds(5'd1, 5'd0, 14'd4, 2'd1), 64'h700, 64'h0, 64'h1, 32'h0, 1'b1, 1'b1, 1'b1},
        '{mk_x(5'd1, 5'd0, 5'd2, 10'd181), 64'h700, 64'h20, 64'h2, 32'h0, 1'b1, 1'b1, 1'b1},
        '{{6'd32, 26'h0}, 64'h700, 64'h0, 64'h3, 32'h0, 1'b0, 1'b0, 1'b0},
        '{mk_ds(5'd1, 5'd4, 14'd1, 2'd2), 64'h700, 64'h0, 64'h4, 32'h0, 1'b0, 1'b0, 1'b0},
        '{mk_ds(5'd15, 5'd8, 14'h2000, 2'd1), 64'h10000, 64'h0, 64'h8877665544332211, 32'h8000, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [1023:0] act,
                       input logic [1023:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected lane image for one access of a store at ea: which=0 first line, 1 second
    task automatic model(input logic [31:0] ea, input logic [63:0] rs, input bit which,
                         output logic [127:0] be, output logic [1023:0] wd);
        logic [31:0] a;
        be = '0;
        wd = '0;
        for (int k = 0; k < 8; k++) begin
            a = ea + 32'(k);
            if ((a[31:7] != ea[31:7]) == which) begin
                be[a[6:0]] = 1'b1;
                wd[a[6:0]*8 +: 8] = rs[63-8*k -: 8];
            end
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [127:0]  ebe;
        logic [1023:0] ewd;
        bit split;
        split = (v.ea[6:0] > 7'd120);
        @(negedge clk);
        instr_word = v.iw; ra_val = v.ra; rb_val = v.rb; rs_val = v.rs;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(illegal == v.bad, $sformatf("R9 vec%0d illegal", idx), illegal, v.bad);
        chk(mem_req == (v.st && !v.bad), $sformatf("R1 vec%0d req", idx), mem_req, v.st && !v.bad);
        chk(resv_kill == 1'b0, $sformatf("R10 vec%0d no kill", idx), resv_kill, 0);
        if (v.st && !v.bad) begin
            model(v.ea, v.rs, 1'b0, ebe, ewd);
            chk(mem_addr == {v.ea[31:7], 7'b0}, $sformatf("R4 R3 R2 vec%0d addr", idx),
                mem_addr, {v.ea[31:7], 7'b0});
            chk(mem_be == ebe, $sformatf("R5 vec%0d be", idx), mem_be, ebe);
            chk(mem_wdata == ewd, $sformatf("R5 vec%0d data", idx), mem_wdata, ewd);
            @(negedge clk);
            if (split) begin
                model(v.ea, v.rs, 1'b1, ebe, ewd);
                chk(mem_req == 1'b1, $sformatf("R6 vec%0d second req", idx), mem_req, 1);
                chk(mem_addr == ({v.ea[31:7], 7'b0} + 32'd128), $sformatf("R6 vec%0d addr2", idx),
                    mem_addr, {v.ea[31:7], 7'b0} + 32'd128);
                chk(mem_be == ebe, $sformatf("R6 vec%0d be2", idx), mem_be, ebe);
                chk(mem_wdata == ewd, $sformatf("R6 vec%0d data2", idx), mem_wdata, ewd);
                @(negedge clk);
            end
            chk(mem_req == 1'b0, $sformatf("R6 vec%0d done", idx), mem_req, 0);
            chk(wb_valid == v.upd, $sformatf("R8 vec%0d wb", idx), wb_valid, v.upd);
            if (v.upd) begin
                chk(wb_idx == v.iw[20:16], $sformatf("R8 vec%0d wb_idx", idx), wb_idx, v.iw[20:16]);
                chk(wb_data == {32'b0, v.ea}, $sformatf("R8 vec%0d wb_data", idx), wb_data, {32'b0, v.ea});
            end
        end else begin
            chk(wb_valid == 1'b0, $sformatf("R9 R1 vec%0d no wb", idx), wb_valid, 0);
            @(negedge clk);
            chk(mem_req == 1'b0 && wb_valid == 1'b0 && illegal == 1'b0,
                $sformatf("R9 R1 vec%0d quiet", idx), {mem_req, wb_valid, illegal}, 0);
        end
    endtask

    // Plain displacement store at address ea; returns resv_kill seen in first request cycle
    task automatic plain_store(input logic [31:0] ea, output logic kill);
        @(negedge clk);
        instr_word = mk_ds(5'd3, 5'd4, 14'd0, 2'd0);
        ra_val = {32'b0, ea}; rs_val = 64'h55; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        kill = resv_kill;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_resv(input logic [31:0] a);
        @(negedge clk);
        resv_set = 1'b1; resv_addr = a;
        @(negedge clk);
        resv_set = 1'b0;
    endtask

    initial begin
        logic k;
        repeat (3) @(negedge clk);
        chk(!mem_req && !busy && !wb_valid && !illegal && !resv_kill, "R11 reset state",
            {mem_req, busy, wb_valid, illegal, resv_kill}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !busy, "R11 after release", {mem_req, busy}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R7: stall acknowledge, present a second instruction while busy
        @(negedge clk);
        mem_ack = 1'b0;
        instr_word = mk_ds(5'd3, 5'd4, 14'd0, 2'd0);
        ra_val = 64'h400; rs_val = 64'h77; instr_valid = 1'b1;
        @(negedge clk);
        ra_val = 64'h800;
        chk(mem_req && busy && mem_addr == 32'h400, "R7 stall start", mem_addr, 32'h400);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(mem_req && mem_addr == 32'h400 && mem_be == 128'hFF, "R7 stall hold",
                mem_addr, 32'h400);
        end
        instr_valid = 1'b0;
        mem_ack = 1'b1;
        @(negedge clk);
        chk(!mem_req && !busy, "R7 released", {mem_req, busy}, 0);
        @(negedge clk);
        chk(!mem_req, "R7 dropped instruction", mem_req, 0);

        // R10: reservation behaviour
        chk(resv_kill == 1'b0, "R11 no reservation after reset", resv_kill, 0);
        set_resv(32'h1010);
        plain_store(32'h1078, k);
        chk(k == 1'b1, "R10 hit same line", k, 1);
        plain_store(32'h1000, k);
        chk(k == 1'b0, "R10 cleared after hit", k, 0);
        set_resv(32'h2080);
        plain_store(32'h2000, k);
        chk(k == 1'b0, "R10 other line", k, 0);
        plain_store(32'h207C, k);
        chk(k == 1'b1, "R10 hit on second line of split", k, 1);

        // R9: illegal form leaves reservation untouched
        set_resv(32'h3000);
        @(negedge clk);
        instr_word = mk_ds(5'd1, 5'd0, 14'd0, 2'd1);
        ra_val = 64'h3000; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(illegal && !resv_kill && !mem_req, "R9 illegal no kill", {illegal, resv_kill, mem_req}, 3'b100);
        plain_store(32'h3008, k);
        chk(k == 1'b1, "R9 reservation kept", k, 1);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule